// File: doc/BRIEF.md
# Ethernet Receive Acceptance Filter

This block makes the accept-or-drop decision for every received Ethernet frame. When a frame ends, the receive path presents the frame's destination address and a set of match flags that earlier logic has already worked out: whether the destination equals the station address, whether the hash table hit, what each of the pattern units reported, and whether a magic packet was seen. The filter sorts the destination into unicast, multicast or broadcast. It forms the acceptance-group result from six enable bits and forms the pattern result from the per-unit enables. It then joins the two with either AND or OR, as a configuration bit selects.

The same frame-end strobe also updates four wake-cause status bits. These bits stay set until software writes a 1 to the matching clear bit. The wake interrupt is high whenever any cause bit is set. The accept decision is registered and appears one clock after the frame-end strobe, together with a single-cycle valid pulse.

Top module: `rx_accept_filter`

## Requirements
- R1: The destination address is presented with its first octet in `dest_addr[47:40]`. An all-ones address is broadcast. An address with `dest_addr[40]` set that is not all ones is multicast. Every other address is unicast.
- R2: The acceptance group is true when any enabled condition holds. The conditions, by `cfg_accept_en` bit, are: bit0 any unicast, bit1 any broadcast, bit2 any multicast, bit3 unicast with `hash_hit`, bit4 multicast with `hash_hit`, bit5 `station_hit`.
- R3: The pattern result is true when some unit `i` has both `pat_hit[i]` and `cfg_pat_en[i]` set. With `cfg_pat_en` all zero the pattern result is false, so in AND mode nothing is accepted.
- R4: With `cfg_and_mode` = 1 the decision is the pattern result AND the acceptance group. With `cfg_and_mode` = 0 the decision is their OR.
- R5: `accept_valid` is high for exactly the one cycle after a cycle with `frame_end` high. In that cycle `accept` carries that frame's decision.
- R6: On `frame_end` with `cfg_wake_filt_en` = 1, the block sets these `wake_status` bits: bit0 when `station_hit` is set; bit1 when the pattern result is true; bit2 when `station_hit`, `hash_hit` or the pattern result is true. With `cfg_wake_filt_en` = 0, none of these bits is set.
- R7: On `frame_end` with `cfg_wake_magic_en` = 1 and `magic_hit` = 1, the block sets `wake_status` bit3. It does not set bit3 when `cfg_wake_magic_en` is 0.
- R8: A `wake_status` bit, once set, holds until a cycle in which the same bit of `wake_clr` is 1. It then reads 0 from the next cycle on. Status changes appear one cycle after the causing input.
- R9: If a cause sets a status bit in the same cycle that `wake_clr` clears it, the bit ends up set.
- R10: `wake_irq` is the OR of the four `wake_status` bits.
- R11: With `frame_end` low, the match inputs have no effect on `accept_valid` or on `wake_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle strobe: the frame's match inputs are valid |
| dest_addr | input | 48 | Destination address, first octet in the top byte |
| station_hit | input | 1 | Destination equals the station address |
| hash_hit | input | 1 | Hash table lookup hit |
| pat_hit | input | 4 | Per pattern unit match flags |
| magic_hit | input | 1 | Magic packet detected in this frame |
| cfg_accept_en | input | 6 | Acceptance-group enables (see R2) |
| cfg_pat_en | input | 4 | Pattern unit enables, bit i for unit i |
| cfg_and_mode | input | 1 | 1: AND pattern with group; 0: OR |
| cfg_wake_filt_en | input | 1 | Address and pattern matches raise wake causes |
| cfg_wake_magic_en | input | 1 | Magic packet raises a wake cause |
| wake_clr | input | 4 | Write-one-to-clear for the wake status bits |
| accept | output | 1 | Registered accept decision |
| accept_valid | output | 1 | One-cycle pulse qualifying `accept` |
| wake_status | output | 4 | Sticky causes: bit0 station, bit1 pattern, bit2 filter, bit3 magic |
| wake_irq | output | 1 | Any wake cause pending |

## Verification
The hardest case to reach is a clear and a new wake cause landing on the same status bit in the same clock. Only that case shows whether a wake event can be lost. The bench creates it by raising `wake_clr` with every bit set in the very cycle that carries a frame-end strobe with a station match. It then checks that the causes for that frame survive while other bits stay clear. A second case that is hard to reach is an idle stretch in which every match input and enable is active but no strobe arrives. The bench holds that stretch for several cycles and confirms that neither the valid pulse nor the status moves.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // acceptance-group enable positions
  localparam int ACC_N       = 6;
  localparam int ACC_UC      = 0;
  localparam int ACC_BC      = 1;
  localparam int ACC_MC      = 2;
  localparam int ACC_UC_HASH = 3;
  localparam int ACC_MC_HASH = 4;
  localparam int ACC_STATION = 5;

  // wake cause positions
  localparam int CAUSE_N       = 4;
  localparam int CAUSE_STATION = 0;
  localparam int CAUSE_PATTERN = 1;
  localparam int CAUSE_FILTER  = 2;
  localparam int CAUSE_MAGIC   = 3;

  typedef struct packed {
    logic uc;
    logic bc;
    logic mc;
  } dst_class_t;

  // group OR over enabled conditions
  function automatic logic group_any(input logic [ACC_N-1:0] en,
                                     input dst_class_t       c,
                                     input logic             hash,
                                     input logic             station);
    logic [ACC_N-1:0] cond;
    cond[ACC_UC]      = c.uc;
    cond[ACC_BC]      = c.bc;
    cond[ACC_MC]      = c.mc;
    cond[ACC_UC_HASH] = c.uc & hash;
    cond[ACC_MC_HASH] = c.mc & hash;
    cond[ACC_STATION] = station;
    return |(cond & en);
  endfunction

  function automatic logic combine(input logic and_mode,
                                   input logic pat,
                                   input logic grp);
    return and_mode ? (pat & grp) : (pat | grp);
  endfunction

endpackage

// File: rtl/rxf_addr_class.sv
module rxf_addr_class
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] dest,
  output dst_class_t        cls
);
  localparam int GROUP_BIT = ADDR_W - 8;

  logic all_ones;
  logic group_bit;

  assign all_ones  = &dest;
  assign group_bit = dest[GROUP_BIT];

  always_comb begin
    cls.bc = all_ones;
    cls.mc = group_bit & ~all_ones;
    cls.uc = ~group_bit;
  end
endmodule

// File: rtl/rxf_accept_core.sv
module rxf_accept_core
  import rxf_pkg::*;
#(
  parameter int NUM_PAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  dst_class_t         cls,
  input  logic               station_hit,
  input  logic               hash_hit,
  input  logic [NUM_PAT-1:0] pat_hit,
  input  logic [ACC_N-1:0]   accept_en,
  input  logic [NUM_PAT-1:0] pat_en,
  input  logic               and_mode,
  output logic               pat_match,
  output logic               grp_match,
  output logic               accept,
  output logic               accept_valid
);
  logic [NUM_PAT-1:0] unit_fire;
  logic               decision;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PAT; gi++) begin : g_unit
      assign unit_fire[gi] = pat_hit[gi] & pat_en[gi];
    end
  endgenerate

  assign pat_match = |unit_fire;
  assign grp_match = group_any(accept_en, cls, hash_hit, station_hit);
  assign decision  = combine(and_mode, pat_match, grp_match);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept       <= 1'b0;
      accept_valid <= 1'b0;
    end else begin
      accept_valid <= frame_end;
      if (frame_end) accept <= decision;
    end
  end

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> accept_valid);
  p_valid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !accept_valid);
  p_and_no_pat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && and_mode && pat_en == '0) |=> !accept);
  p_or_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !and_mode && grp_match) |=> accept);
  p_and_pat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && and_mode && !pat_match) |=> !accept);
endmodule

// File: rtl/rxf_wake_status.sv
module rxf_wake_status #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_vec,
  input  logic [NBITS-1:0] clr_vec,
  output logic [NBITS-1:0] status,
  output logic             irq
);
  genvar gi;
  generate
    for (gi = 0; gi < NBITS; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)              status[gi] <= 1'b0;
        else if (set_vec[gi])    status[gi] <= 1'b1;
        else if (clr_vec[gi])    status[gi] <= 1'b0;
      end

      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[gi] && !clr_vec[gi]) |=> status[gi]);
      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[gi] && !set_vec[gi]) |=> !status[gi]);
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[gi] |=> status[gi]);
    end
  endgenerate

  assign irq = |status;

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|set_vec));
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_PAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [ADDR_W-1:0]  dest_addr,
  input  logic               station_hit,
  input  logic               hash_hit,
  input  logic [NUM_PAT-1:0] pat_hit,
  input  logic               magic_hit,
  input  logic [ACC_N-1:0]   cfg_accept_en,
  input  logic [NUM_PAT-1:0] cfg_pat_en,
  input  logic               cfg_and_mode,
  input  logic               cfg_wake_filt_en,
  input  logic               cfg_wake_magic_en,
  input  logic [CAUSE_N-1:0] wake_clr,
  output logic               accept,
  output logic               accept_valid,
  output logic [CAUSE_N-1:0] wake_status,
  output logic               wake_irq
);
  dst_class_t         cls;
  logic               pat_match;
  logic               grp_match;
  logic               filt_arm;
  logic               magic_arm;
  logic [CAUSE_N-1:0] wake_set;

  rxf_addr_class #(.ADDR_W(ADDR_W)) u_class (
    .dest (dest_addr),
    .cls  (cls)
  );

  rxf_accept_core #(.NUM_PAT(NUM_PAT)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .cls          (cls),
    .station_hit  (station_hit),
    .hash_hit     (hash_hit),
    .pat_hit      (pat_hit),
    .accept_en    (cfg_accept_en),
    .pat_en       (cfg_pat_en),
    .and_mode     (cfg_and_mode),
    .pat_match    (pat_match),
    .grp_match    (grp_match),
    .accept       (accept),
    .accept_valid (accept_valid)
  );

  assign filt_arm  = frame_end & cfg_wake_filt_en;
  assign magic_arm = frame_end & cfg_wake_magic_en;

  always_comb begin
    wake_set                = '0;
    wake_set[CAUSE_STATION] = filt_arm & station_hit;
    wake_set[CAUSE_PATTERN] = filt_arm & pat_match;
    wake_set[CAUSE_FILTER]  = filt_arm & (station_hit | hash_hit | pat_match);
    wake_set[CAUSE_MAGIC]   = magic_arm & magic_hit;
  end

  rxf_wake_status #(.NBITS(CAUSE_N)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (wake_set),
    .clr_vec (wake_clr),
    .status  (wake_status),
    .irq     (wake_irq)
  );

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && wake_clr == '0) |=> wake_status == $past(wake_status));
  p_magic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cfg_wake_magic_en && magic_hit) |=> wake_status[CAUSE_MAGIC]);
  p_filt_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !cfg_wake_filt_en && wake_status[2:0] == 3'b000) |=> wake_status[2:0] == 3'b000);
endmodule

// File: tb/rx_accept_filter_bench.sv
`timescale 1ns/1ps
module rx_accept_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_end = 1'b0;
  logic [47:0] dest_addr = '0;
  logic        station_hit = 1'b0;
  logic        hash_hit = 1'b0;
  logic [3:0]  pat_hit = '0;
  logic        magic_hit = 1'b0;
  logic [5:0]  cfg_accept_en = '0;
  logic [3:0]  cfg_pat_en = '0;
  logic        cfg_and_mode = 1'b0;
  logic        cfg_wake_filt_en = 1'b0;
  logic        cfg_wake_magic_en = 1'b0;
  logic [3:0]  wake_clr = '0;
  logic        accept;
  logic        accept_valid;
  logic [3:0]  wake_status;
  logic        wake_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_accept_filter u_rx_accept_filter (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .dest_addr(dest_addr),
    .station_hit(station_hit), .hash_hit(hash_hit), .pat_hit(pat_hit),
    .magic_hit(magic_hit), .cfg_accept_en(cfg_accept_en), .cfg_pat_en(cfg_pat_en),
    .cfg_and_mode(cfg_and_mode), .cfg_wake_filt_en(cfg_wake_filt_en),
    .cfg_wake_magic_en(cfg_wake_magic_en), .wake_clr(wake_clr),
    .accept(accept), .accept_valid(accept_valid),
    .wake_status(wake_status), .wake_irq(wake_irq)
  );

  localparam logic [47:0] UC = 48'h0012_3456_789A;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;

  typedef struct packed {
    logic [47:0] dest;
    logic        st;
    logic        hs;
    logic [3:0]  pat;
    logic [5:0]  aen;
    logic [3:0]  pen;
    logic        andm;
    logic        exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{UC, 1'b0, 1'b0, 4'b0000, 6'b000001, 4'b0000, 1'b0, 1'b1}, // R1 R2 unicast
    '{BC, 1'b0, 1'b0, 4'b0000, 6'b000001, 4'b0000, 1'b0, 1'b0}, // R1 bcast not uc
    '{BC, 1'b0, 1'b0, 4'b0000, 6'b000010, 4'b0000, 1'b0, 1'b1}, // R2 bcast
    '{MC, 1'b0, 1'b0, 4'b0000, 6'b000010, 4'b0000, 1'b0, 1'b0}, // R1 mcast not bc
    '{MC, 1'b0, 1'b0, 4'b0000, 6'b000100, 4'b0000, 1'b0, 1'b1}, // R2 mcast
    '{UC, 1'b0, 1'b1, 4'b0000, 6'b001000, 4'b0000, 1'b0, 1'b1}, // R2 uc hash
    '{MC, 1'b0, 1'b1, 4'b0000, 6'b001000, 4'b0000, 1'b0, 1'b0}, // R2 uc hash on mc
    '{MC, 1'b0, 1'b1, 4'b0000, 6'b010000, 4'b0000, 1'b0, 1'b1}, // R2 mc hash
    '{MC, 1'b0, 1'b0, 4'b0000, 6'b010000, 4'b0000, 1'b0, 1'b0}, // R2 mc hash miss
    '{UC, 1'b1, 1'b0, 4'b0000, 6'b100000, 4'b0000, 1'b0, 1'b1}, // R2 station
    '{UC, 1'b0, 1'b0, 4'b0000, 6'b100000, 4'b0000, 1'b0, 1'b0}, // R2 station miss
    '{UC, 1'b0, 1'b0, 4'b0100, 6'b000000, 4'b0100, 1'b0, 1'b1}, // R3 R4 or pattern
    '{UC, 1'b0, 1'b0, 4'b0100, 6'b000000, 4'b1011, 1'b0, 1'b0}, // R3 unit disabled
    '{UC, 1'b0, 1'b0, 4'b0001, 6'b000001, 4'b0001, 1'b1, 1'b1}, // R4 and both
    '{UC, 1'b0, 1'b0, 4'b0000, 6'b000001, 4'b0001, 1'b1, 1'b0}, // R4 and no pat
    '{UC, 1'b0, 1'b0, 4'b1111, 6'b000001, 4'b0000, 1'b1, 1'b0}, // R3 zero enables
    '{BC, 1'b0, 1'b0, 4'b1000, 6'b000001, 4'b1000, 1'b1, 1'b0}, // R4 and no group
    '{UC, 1'b1, 1'b1, 4'b0000, 6'b000000, 4'b0000, 1'b0, 1'b0}  // R2 nothing enabled
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse frame_end at a negedge; returns at the next negedge, after the update
  task automatic pulse_frame;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic clear_bits(input logic [3:0] m);
    wake_clr = m;
    @(negedge clk);
    wake_clr = '0;
  endtask

  task automatic idle_inputs;
    station_hit = 1'b0; hash_hit = 1'b0; pat_hit = '0; magic_hit = 1'b0;
    dest_addr = UC;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R5 reset valid", {7'd0, accept_valid}, 8'd0);
    check("R8 reset status", {4'd0, wake_status}, 8'd0);
    check("R10 reset irq", {7'd0, wake_irq}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      dest_addr = TBL[i].dest; station_hit = TBL[i].st; hash_hit = TBL[i].hs;
      pat_hit = TBL[i].pat; cfg_accept_en = TBL[i].aen; cfg_pat_en = TBL[i].pen;
      cfg_and_mode = TBL[i].andm;
      pulse_frame();
      check("R5 valid pulse", {7'd0, accept_valid}, 8'd1);
      check($sformatf("R4 accept vec %0d", i), {7'd0, accept}, {7'd0, TBL[i].exp});
      @(negedge clk);
      check("R5 valid single", {7'd0, accept_valid}, 8'd0);
    end
    check("R6 filter wake off", {4'd0, wake_status}, 8'd0);
    cfg_and_mode = 1'b0; cfg_accept_en = '0; cfg_pat_en = '0;

    // R6 station cause
    idle_inputs();
    cfg_wake_filt_en = 1'b1;
    station_hit = 1'b1;
    pulse_frame();
    idle_inputs();
    check("R6 station causes", {4'd0, wake_status}, 8'h05);
    check("R10 irq set", {7'd0, wake_irq}, 8'd1);
    repeat (4) @(negedge clk);
    check("R8 sticky hold", {4'd0, wake_status}, 8'h05);
    pulse_frame();
    check("R8 empty frame keeps", {4'd0, wake_status}, 8'h05);
    clear_bits(4'b0001);
    check("R8 partial clear", {4'd0, wake_status}, 8'h04);
    clear_bits(4'b0100);
    check("R8 full clear", {4'd0, wake_status}, 8'h00);
    check("R10 irq clear", {7'd0, wake_irq}, 8'd0);

    // R6 pattern cause
    cfg_pat_en = 4'b0010; pat_hit = 4'b0010;
    pulse_frame();
    idle_inputs();
    check("R6 pattern causes", {4'd0, wake_status}, 8'h06);
    clear_bits(4'b1111);
    // R6 hash only
    hash_hit = 1'b1;
    pulse_frame();
    idle_inputs();
    check("R6 hash cause", {4'd0, wake_status}, 8'h04);
    clear_bits(4'b1111);
    // R6 disabled
    cfg_wake_filt_en = 1'b0; station_hit = 1'b1; hash_hit = 1'b1; pat_hit = 4'b0010;
    pulse_frame();
    idle_inputs();
    check("R6 disabled", {4'd0, wake_status}, 8'h00);

    // R7 magic
    cfg_wake_magic_en = 1'b1; magic_hit = 1'b1;
    pulse_frame();
    idle_inputs();
    check("R7 magic set", {4'd0, wake_status}, 8'h08);
    clear_bits(4'b1000);
    cfg_wake_magic_en = 1'b0; magic_hit = 1'b1;
    pulse_frame();
    idle_inputs();
    check("R7 magic disabled", {4'd0, wake_status}, 8'h00);

    // R9 set beats clear
    cfg_wake_filt_en = 1'b1; station_hit = 1'b1; wake_clr = 4'b1111;
    pulse_frame();
    wake_clr = '0;
    idle_inputs();
    check("R9 set wins", {4'd0, wake_status}, 8'h05);
    clear_bits(4'b1111);
    check("R9 cleared after", {4'd0, wake_status}, 8'h00);

    // R11 no strobe, everything active
    cfg_wake_magic_en = 1'b1; cfg_accept_en = 6'b111111; cfg_pat_en = 4'b1111;
    station_hit = 1'b1; hash_hit = 1'b1; pat_hit = 4'b1111; magic_hit = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R11 no valid", {7'd0, accept_valid}, 8'd0);
      check("R11 no status", {4'd0, wake_status}, 8'h00);
    end
    idle_inputs();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule